// File: doc/BRIEF.md
# Prescaled Compare Timer

This peripheral divides the system clock by a selectable power of two and counts the divided ticks upward in a counter. Each tick compares the counter's next value with a programmable limit. A match latches an event flag, and the flag can raise an interrupt. An optional auto-restart returns the counter to zero in the matching tick itself. The period then equals exactly the limit in ticks, whatever the software's response time. For example, with a 16 MHz clock, a divide-by-16 setting (N=4) and a limit of 1000, the flag fires once per millisecond. A limit of 5000 gives one event every 5 ms.

Software drives the block through plain write and read strobes on a two-bit register address. Three single-cycle strobes start, stop and clear the count. The event flag stays set until software writes zero to it.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset every register reads zero, irq_o is low and the counter is stopped.
- R2: The counter advances only while running. A start strobe begins running and a stop strobe ends it, taking effect at the next edge. While stopped the count holds.
- R3: The divide setting N is held in CTRL bits [7:4]. While running, one tick occurs every 2^N running cycles, counted from the last clear. Settings above 9 act as 9.
- R4: A new N written to CTRL does not alter the tick in progress. It is adopted at the next tick, or at a clear strobe.
- R5: A tick whose incremented count equals LIMIT sets the event flag, which is bit 0 of the EVENT register.
- R6: When the auto-restart bit (CTRL bit 0) is set, a matching tick loads zero into the counter instead of LIMIT, giving a period of LIMIT ticks.
- R7: When the auto-restart bit is clear, the counter continues past LIMIT and wraps to zero after all ones.
- R8: The event flag stays set until a write of zero to EVENT. A write of any non-zero value to EVENT has no effect.
- R9: When a matching tick and a zero write to EVENT fall in the same cycle, the flag ends up set.
- R10: irq_o is a register that follows the event flag ANDed with the interrupt-enable bit (CTRL bit 1), one cycle later.
- R11: A clear strobe zeroes the counter and the divider phase. When it coincides with a tick, the clear wins.
- R12: A read strobe returns the addressed register on rd_data_o one cycle later. The addresses are: 0 CTRL, 1 LIMIT, 2 EVENT, 3 COUNT (read-only).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin counting strobe |
| stop_i | input | 1 | Halt counting strobe |
| clear_i | input | 1 | Zero counter and divider phase |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | DATA_W | Read data, valid one cycle after the strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
Two collisions are provoked. In the first, the compare match that sets the event flag shares a cycle with the software write of zero that clears it. The bench positions the write so that it lands on the fifth tick against a limit of five, and expects the flag to read back as set with the count at one afterwards. In the second, a clear strobe shares an edge with a running tick. The count must read zero rather than one more than before.

// File: rtl/tct_pkg.sv
package tct_pkg;
  localparam int PS_W = 4;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_LIMIT = 2'd1,
    A_EVENT = 2'd2,
    A_COUNT = 2'd3
  } tct_addr_e;

  // bits [7:4] divide select, [1] interrupt enable, [0] auto-restart
  typedef struct packed {
    logic [PS_W-1:0] psel;
    logic [1:0]      rsvd;
    logic            irq_en;
    logic            restart;
  } tct_ctrl_t;
endpackage

// File: rtl/tct_prescale.sv
module tct_prescale #(
  parameter int PS_MAX = 9,
  parameter int PS_W   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            clr,
  input  logic [PS_W-1:0] psel_cfg,
  output logic            tick
);
  localparam int PH_W = (PS_MAX < 1) ? 1 : PS_MAX;

  logic [PS_W-1:0] act_q, cfg_sat;
  logic [PH_W-1:0] phase_q, mask;

  assign cfg_sat = (psel_cfg > PS_W'(PS_MAX)) ? PS_W'(PS_MAX) : psel_cfg;
  assign mask    = ~({PH_W{1'b1}} << act_q);
  assign tick    = run && (phase_q == mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= '0;
      phase_q <= '0;
    end else if (clr) begin
      act_q   <= cfg_sat;
      phase_q <= '0;
    end else if (tick) begin
      act_q   <= cfg_sat;
      phase_q <= '0;
    end else if (run) begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/tct_counter.sv
module tct_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clr,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q, nxt;

  assign nxt     = cnt_q + 1'b1;
  assign match_o = tick && !clr && (nxt == limit);
  assign count_o = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= (match_o && restart) ? '0 : nxt;
  end
endmodule

// File: rtl/tct_regs.sv
module tct_regs
  import tct_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  input  logic              match,
  input  logic [CNT_W-1:0]  count,
  output tct_ctrl_t         ctrl_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic              event_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] rd_data_o
);
  tct_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] limit_q;
  logic             event_q, irq_q, evt_wipe;
  logic [DATA_W-1:0] rd_q;

  assign evt_wipe = wr_en && (tct_addr_e'(wr_addr) == A_EVENT) && (wr_data == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      limit_q <= '0;
    end else if (wr_en) begin
      case (tct_addr_e'(wr_addr))
        A_CTRL: begin
          ctrl_q      <= tct_ctrl_t'(wr_data[7:0]);
          ctrl_q.rsvd <= '0;
        end
        A_LIMIT: limit_q <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // a match outranks a same-cycle wipe so no event is lost
  always_ff @(posedge clk) begin
    if (rst)           event_q <= 1'b0;
    else if (match)    event_q <= 1'b1;
    else if (evt_wipe) event_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= event_q && ctrl_q.irq_en;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (rd_en) begin
      case (tct_addr_e'(rd_addr))
        A_CTRL:  rd_q <= DATA_W'(ctrl_q);
        A_LIMIT: rd_q <= DATA_W'(limit_q);
        A_EVENT: rd_q <= DATA_W'(event_q);
        default: rd_q <= DATA_W'(count);
      endcase
    end
  end

  assign ctrl_o    = ctrl_q;
  assign limit_o   = limit_q;
  assign event_o   = event_q;
  assign irq_o     = irq_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
  import tct_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int PS_MAX = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              clear_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  tct_ctrl_t        ctrl;
  logic [CNT_W-1:0] limit, count;
  logic             run_q, tick, match, event_f, sc_en, ie_en;

  assign sc_en = ctrl.restart;
  assign ie_en = ctrl.irq_en;

  always_ff @(posedge clk) begin
    if (rst || stop_i) run_q <= 1'b0;
    else if (start_i)  run_q <= 1'b1;
  end

  tct_prescale #(.PS_MAX(PS_MAX), .PS_W(PS_W)) u_ps (
    .clk(clk), .rst(rst), .run(run_q), .clr(clear_i),
    .psel_cfg(ctrl.psel), .tick(tick)
  );

  tct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .clr(clear_i), .restart(sc_en),
    .limit(limit), .count_o(count), .match_o(match)
  );

  tct_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .rd_en(rd_en_i), .rd_addr(rd_addr_i),
    .match(match), .count(count), .ctrl_o(ctrl), .limit_o(limit),
    .event_o(event_f), .irq_o(irq_o), .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/tct_checks.sv
module tct_checks #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              tick,
  input logic              clr,
  input logic              sc_en,
  input logic              ie_en,
  input logic              event_f,
  input logic              irq,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  limit
);
  logic [CNT_W-1:0] nxt;
  logic hit, wipe;
  assign nxt  = count + 1'b1;
  assign hit  = tick && !clr && (nxt == limit);
  assign wipe = wr_en && (wr_addr == 2'd2) && (wr_data == '0);

  a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(count));
  a_r5_match_sets_flag: assert property (@(posedge clk) disable iff (rst)
    hit |=> event_f);
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (rst)
    (hit && sc_en) |=> (count == '0));
  a_r7_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr && (count == '1)) |=> (count == '0));
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (event_f && !wipe) |=> event_f);
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (rst)
    !ie_en |=> !irq);
  a_r11_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));
endmodule

bind tick_cmp_timer tct_checks #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .run(run_q), .tick(tick), .clr(clear_i),
  .sc_en(sc_en), .ie_en(ie_en), .event_f(event_f), .irq(irq_o),
  .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
  .count(count), .limit(limit)
);

// File: tb/tick_cmp_timer_tb_top.sv
module tick_cmp_timer_tb_top;
  localparam int CW = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, stop_i = 0, clear_i = 0, wr_en_i = 0, rd_en_i = 0;
  logic [1:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic irq_o;

  always #2 clk = ~clk;

  tick_cmp_timer #(.CNT_W(CW), .DATA_W(DW), .PS_MAX(9)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .clear_i(clear_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  typedef struct { logic [DW-1:0] exp; string tag; } item_t;
  item_t sb_q[$];
  int n_vec = 0, n_bad = 0;
  logic rd_pend = 1'b0;
  bit done = 0;

  always @(posedge clk) rd_pend <= rd_en_i;

  // monitor: compares each read result against the queued expectation
  always @(negedge clk) begin
    if (rd_pend) begin
      item_t it;
      n_vec++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL R12 unexpected read data got %0h expected none", rd_data_o);
      end else begin
        it = sb_q.pop_front();
        if (rd_data_o !== it.exp) begin
          n_bad++;
          $display("FAIL %s got %0h expected %0h", it.tag, rd_data_o, it.exp);
        end
      end
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d; cyc(1); wr_en_i = 0;
  endtask

  task automatic rd_exp(logic [1:0] a, logic [DW-1:0] e, string tag);
    item_t it; it.exp = e; it.tag = tag; sb_q.push_back(it);
    rd_en_i = 1; rd_addr_i = a; cyc(1); rd_en_i = 0;
  endtask

  task automatic pulse_clear; clear_i = 1; cyc(1); clear_i = 0; endtask

  // exactly k running cycles (k >= 1)
  task automatic run_cycles(int k);
    start_i = 1; cyc(1); start_i = 0;
    if (k > 1) cyc(k - 1);
    stop_i = 1; cyc(1); stop_i = 0;
  endtask

  task automatic chk_irq(logic e, string tag);
    n_vec++;
    if (irq_o !== e) begin
      n_bad++;
      $display("FAIL %s irq_o got %0b expected %0b", tag, irq_o, e);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    cyc(3); rst = 0; cyc(1);
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd_exp(2'd0, 0, "R1 ctrl"); rd_exp(2'd1, 0, "R1 limit");
    rd_exp(2'd2, 0, "R1 event"); rd_exp(2'd3, 0, "R1 count");
    cyc(5); rd_exp(2'd3, 0, "R2 idle after reset");

    // auto-restart, limit 5, seven ticks
    wr(2'd1, 5); wr(2'd0, 32'h03); pulse_clear();
    run_cycles(7);
    rd_exp(2'd3, 2, "R6 restart count");
    rd_exp(2'd2, 1, "R5 event set");
    rd_exp(2'd0, 32'h03, "R12 ctrl readback");
    cyc(1); chk_irq(1'b1, "R10 irq on");
    cyc(20); rd_exp(2'd3, 2, "R2 stopped holds");
    rd_exp(2'd2, 1, "R8 flag persists");
    wr(2'd2, 0); cyc(2); chk_irq(1'b0, "R10 irq off");
    rd_exp(2'd2, 0, "R8 zero write clears");
    wr(2'd2, 1); rd_exp(2'd2, 0, "R8 nonzero write ignored");

    // no restart, limit 3, irq disabled
    wr(2'd0, 32'h00); wr(2'd1, 3); pulse_clear();
    run_cycles(5);
    rd_exp(2'd3, 5, "R7 passes limit");
    rd_exp(2'd2, 1, "R5 event no restart");
    cyc(1); chk_irq(1'b0, "R10 masked");
    wr(2'd0, 32'h02); cyc(2); chk_irq(1'b1, "R10 enable late");
    wr(2'd0, 32'h00); wr(2'd2, 0);

    // wrap through all ones of a 12-bit counter
    wr(2'd1, 4000); pulse_clear();
    run_cycles(4099);
    rd_exp(2'd3, 3, "R7 wrap");
    rd_exp(2'd2, 1, "R5 event before wrap");
    wr(2'd2, 0);

    // divide by 4, then switch to 1 mid period
    wr(2'd1, 100); wr(2'd0, 32'h21); pulse_clear();
    run_cycles(10);
    rd_exp(2'd3, 2, "R3 divide by 4");
    wr(2'd0, 32'h01);
    run_cycles(2);
    rd_exp(2'd3, 3, "R4 old divide finishes");
    run_cycles(3);
    rd_exp(2'd3, 6, "R4 new divide active");

    // clear strobe
    pulse_clear();
    rd_exp(2'd3, 0, "R11 clear zeroes");
    start_i = 1; cyc(1); start_i = 0; cyc(1);
    clear_i = 1; stop_i = 1; cyc(1); clear_i = 0; stop_i = 0;
    rd_exp(2'd3, 0, "R11 clear beats tick");
    wr(2'd0, 32'h21); pulse_clear();
    run_cycles(3);
    pulse_clear();
    run_cycles(3);
    rd_exp(2'd3, 0, "R11 phase cleared");

    // match and zero write in the same cycle
    wr(2'd0, 32'h03); wr(2'd1, 5); wr(2'd2, 0); pulse_clear();
    start_i = 1; cyc(1); start_i = 0; cyc(4);
    wr_en_i = 1; wr_addr_i = 2'd2; wr_data_i = 0; cyc(1); wr_en_i = 0;
    stop_i = 1; cyc(1); stop_i = 0;
    rd_exp(2'd2, 1, "R9 set wins");
    rd_exp(2'd3, 1, "R9 count after");
    wr(2'd2, 0);
    rd_exp(2'd2, 0, "R8 clear after collision");

    cyc(4);
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R12 reads outstanding got %0d expected 0", sb_q.size());
    end
    report();
  end
endmodule